// File: doc/BRIEF.md
# SHA-1 Two-Round Compression Engine

This block applies the SHA-1 compression function to one padded 512-bit message block and folds the result into a 160-bit chaining value. The message schedule lives outside the block. A separate scheduler keeps a 16-deep circular buffer of pre-summed words, where each word is the schedule word W[i] with the round constant K(i) already added. The engine reads two of those words per clock and retires two chained rounds in that clock. A whole block therefore takes 40 busy cycles.

A host puts the starting chaining value on `chain_in` and pulses `start` while the engine is idle. The engine copies that value into its working words A..E and also into its chaining register. It then steps through the round pairs. In the last pair it adds the final working words into the chaining register, modulo 2^32 word by word, and raises `done` for one cycle. The host may chain blocks by feeding `chain_out` back as the next `chain_in`. Padding and length encoding are the host's job.

Top module: `sha1_dual_round_core`

## Requirements
- R1: While reset is held and after it, `busy` and `done` are 0 and `chain_out` is all zeros.
- R2: A `start` sampled high while `busy` is 0 loads `chain_in` into `chain_out` and sets `busy` at the same clock edge. `chain_in` is packed as A in bits 159:128, then B, C and D, with E in bits 31:0.
- R3: In the k-th busy cycle (k = 0..39), `wk_raddr` equals (2k) mod 16. In that cycle the engine consumes entry 2k through `wk_lo` and entry 2k+1 through `wk_hi`.
- R4: Each busy cycle performs rounds 2k and 2k+1 in that order. A round sets the new A to F(B,C,D) + E + (A rol 5) + word, then shifts the words: B takes the old A, C takes the old B rol 30, D takes the old C and E takes the old D. F is D^(B&(C^D)) in rounds 0-19, B^C^D in rounds 20-39, (B&C)|(D&(B^C)) in rounds 40-59, and B^C^D in rounds 60-79.
- R5: At the edge that ends the 40th busy cycle, each chaining word becomes its old value plus the matching final working word, modulo 2^32. For the padded message "abc" with the standard initial value, this gives A9993E36 4706816A BA3E2571 7850C26C 9CD0D89D.
- R6: `done` is high for exactly one cycle. It rises 40 clock edges after the start edge, and `busy` falls at the same edge.
- R7: A `start` sampled while `busy` is 1 has no effect. It neither reloads the state nor alters the result.
- R8: While `busy` is 0 and no `start` is sampled, `chain_out` holds its value.
- R9: A digest fed back as the next `chain_in` is processed as the chaining value of a following block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block when idle |
| chain_in | input | 160 | Chaining value to load, A in the top word |
| wk_lo | input | 32 | Buffer entry at `wk_raddr` (even round word) |
| wk_hi | input | 32 | Buffer entry at `wk_raddr`+1 (odd round word) |
| wk_raddr | output | 4 | Buffer index of the even entry for this cycle |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse after the final addition |
| chain_out | output | 160 | Chaining value, A in the top word |

## Verification
`start` is sampled at edge E0. `chain_out` shows the loaded value and `busy` is high from E0. The read index for pair k is valid between edges Ek and Ek+1, and the bench drives the matching buffer words in that interval. The updated digest and the `done` pulse appear after E40, and `done` is low again after E41. All checks are made at the falling edge inside these intervals. The read index is checked for every pair, which covers the wrap of the 16-entry buffer. Digests are compared against a bench model that computes the schedule and adds the constants itself, and against the fixed "abc" value.

// File: rtl/sha1_dual_round_core.sv
module sha1_dual_round_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [159:0] chain_in,
  input  logic [31:0]  wk_lo,
  input  logic [31:0]  wk_hi,
  output logic [3:0]   wk_raddr,
  output logic         busy,
  output logic         done,
  output logic [159:0] chain_out
);
  localparam int PAIRS = 40;
  localparam int CW = $clog2(PAIRS);

  logic [31:0] a, b, c, d, e;
  logic [159:0] h;
  logic [CW-1:0] pair;
  logic busy_q, done_q;
  logic [1:0] phase;

  function automatic logic [31:0] fsel(input logic [1:0] ph, input logic [31:0] x, y, z);
    case (ph)
      2'd0: fsel = z ^ (x & (y ^ z));
      2'd2: fsel = (x & y) | (z & (x ^ y));
      default: fsel = x ^ y ^ z;
    endcase
  endfunction

  function automatic logic [31:0] rl5(input logic [31:0] x);
    rl5 = {x[26:0], x[31:27]};
  endfunction

  function automatic logic [31:0] rl30(input logic [31:0] x);
    rl30 = {x[1:0], x[31:2]};
  endfunction

  assign phase = (pair < CW'(10)) ? 2'd0 :
                 (pair < CW'(20)) ? 2'd1 :
                 (pair < CW'(30)) ? 2'd2 : 2'd3;

  logic [31:0] a1, a2;
  assign a1 = fsel(phase, b, c, d) + e + rl5(a) + wk_lo;
  assign a2 = fsel(phase, a, rl30(b), c) + d + rl5(a1) + wk_hi;

  assign wk_raddr  = {pair[2:0], 1'b0};
  assign busy      = busy_q;
  assign done      = done_q;
  assign chain_out = h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {a, b, c, d, e} <= '0;
      h      <= '0;
      pair   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          {a, b, c, d, e} <= chain_in;
          h      <= chain_in;
          pair   <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        a <= a2;
        b <= a1;
        c <= rl30(a);
        d <= rl30(b);
        e <= c;
        pair <= pair + CW'(1);
        if (pair == CW'(PAIRS - 1)) begin
          h <= {h[159:128] + a2, h[127:96] + a1, h[95:64] + rl30(a),
                h[63:32] + rl30(b), h[31:0] + c};
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sha1_dual_round_core_chk.sv
module sha1_dual_round_core_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [3:0]   wk_raddr,
  input logic [159:0] chain_out
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done));
  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(chain_out));
  // R3
  raddr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (wk_raddr == 4'd0));
  // R3
  raddr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (!busy || wk_raddr == 4'($past(wk_raddr) + 4'd2)));
endmodule

bind sha1_dual_round_core sha1_dual_round_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wk_raddr(wk_raddr), .chain_out(chain_out)
);

// File: tb/sha1_dual_round_core_test.sv
`timescale 1ns/1ps
module sha1_dual_round_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [159:0] chain_in = '0;
  logic [31:0] wk_lo = '0, wk_hi = '0;
  logic [3:0] wk_raddr;
  logic busy, done;
  logic [159:0] chain_out;

  int tests = 0, fails = 0;
  logic [31:0] w [80];
  logic [31:0] wk [80];

  localparam logic [159:0] IV = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;
  localparam logic [511:0] ABC = {32'h61626380, {14{32'h0}}, 32'h00000018};
  localparam logic [159:0] ABC_DIG = 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D;

  typedef struct packed {
    logic [159:0] init;
    logic [511:0] blk;
    logic         lit;
    logic [159:0] dig;
  } vec_t;

  localparam vec_t TBL [4] = '{
    '{IV, ABC, 1'b1, ABC_DIG},
    '{IV, {512{1'b1}}, 1'b0, 160'h0},
    '{160'h0, {8{64'h0123456789ABCDEF}}, 1'b0, 160'h0},
    '{{160{1'b1}}, {16{32'h80000001}}, 1'b0, 160'h0}
  };

  sha1_dual_round_core uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_in(chain_in),
    .wk_lo(wk_lo), .wk_hi(wk_hi), .wk_raddr(wk_raddr),
    .busy(busy), .done(done), .chain_out(chain_out)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] rol(input logic [31:0] x, input int n);
    rol = (x << n) | (x >> (32 - n));
  endfunction

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic prep(input logic [511:0] blk);
    for (int i = 0; i < 80; i++) begin
      if (i < 16) w[i] = blk[511 - 32*i -: 32];
      else w[i] = rol(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
      wk[i] = w[i] + (i < 20 ? 32'h5A827999 : i < 40 ? 32'h6ED9EBA1 :
                      i < 60 ? 32'h8F1BBCDC : 32'hCA62C1D6);
    end
  endtask

  task automatic ref_hash(input logic [159:0] init, output logic [159:0] dig);
    logic [31:0] a, b, c, d, e, f, t;
    {a, b, c, d, e} = init;
    for (int i = 0; i < 80; i++) begin
      if (i < 20) f = (b & c) | (~b & d);
      else if (i >= 40 && i < 60) f = (b & c) | (b & d) | (c & d);
      else f = b ^ c ^ d;
      t = rol(a, 5) + f + e + wk[i];
      e = d; d = c; c = rol(b, 30); b = a; a = t;
    end
    dig = {init[159:128] + a, init[127:96] + b, init[95:64] + c,
           init[63:32] + d, init[31:0] + e};
  endtask

  task automatic run_block(input logic [159:0] init, input logic [511:0] blk,
                           input logic [159:0] exp, input bit mid_start,
                           output logic [159:0] got);
    prep(blk);
    @(negedge clk);
    start = 1'b1; chain_in = init;
    @(negedge clk);
    start = 1'b0; chain_in = ~init;
    check(busy === 1'b1 && chain_out === init, "R2", chain_out, init);
    for (int k = 0; k < 40; k++) begin
      check(wk_raddr === 4'((2*k) % 16) && busy === 1'b1 && done === 1'b0, "R3",
            {156'h0, wk_raddr}, 160'((2*k) % 16));
      wk_lo = wk[2*k]; wk_hi = wk[2*k+1];
      start = mid_start && (k == 5 || k == 39);
      if (k == 10) check(chain_out === init, "R7", chain_out, init);
      @(negedge clk);
    end
    start = 1'b0;
    check(done === 1'b1 && busy === 1'b0, "R6", {158'h0, done, busy}, 160'h2);
    check(chain_out === exp, "R5", chain_out, exp);
    got = chain_out;
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R6", {158'h0, done, busy}, 160'h0);
    check(chain_out === exp, "R8", chain_out, exp);
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [159:0] got, exp, dig1;
    #20;
    check(busy === 1'b0 && done === 1'b0 && chain_out === 160'h0, "R1", chain_out, 160'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && chain_out === 160'h0, "R1", chain_out, 160'h0);

    for (int i = 0; i < 4; i++) begin
      prep(TBL[i].blk);
      ref_hash(TBL[i].init, exp);
      if (TBL[i].lit) exp = TBL[i].dig;
      run_block(TBL[i].init, TBL[i].blk, exp, 1'b0, got); // R4
    end

    // R5 fixed "abc" digest, with stray starts mid-run (R7)
    run_block(IV, ABC, ABC_DIG, 1'b1, dig1);

    // R9 chained second block
    prep({16{32'hDEADBEEF}});
    ref_hash(dig1, exp);
    run_block(dig1, {16{32'hDEADBEEF}}, exp, 1'b0, got);

    // R8 idle hold over several cycles with inputs moving
    repeat (5) begin
      chain_in = ~chain_in; wk_lo = ~wk_lo;
      @(negedge clk);
      check(chain_out === exp && busy === 1'b0, "R8", chain_out, exp);
    end

    // R1 reset mid-run
    @(negedge clk); start = 1'b1; chain_in = IV;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy === 1'b0 && done === 1'b0 && chain_out === 160'h0, "R1", chain_out, 160'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule